// File: doc/BRIEF.md
# Cubic Edge Enhancement Pixel Filter

This block sharpens one pixel per clock. Each accepted input carries a centre pixel and its four direct neighbours (above, below, left, right), all 8-bit unsigned. The block forms a signed high-pass edge value by weighting the centre by four and subtracting the neighbours. It then cubes that value, which makes strong edges much stronger while leaving weak ones small. The cube is scaled down by a power-of-two arithmetic shift and saturated. The result is added back to the centre, and the sum is clamped into the 8-bit pixel range.

The datapath is a fixed five-stage pipeline with a register after every arithmetic step. A valid flag travels alongside the data. There is no stall input, so a result appears exactly five clocks after its input and the block accepts a new pixel every clock.

Top module: `edge_cube_filter`

## Requirements
- R1: The edge value is 4·centre − above − below − left − right, computed as a signed quantity that covers the full range −1020 to +1020 without wrapping.
- R2: The edge value is cubed exactly. Magnitudes up to 1020³ are kept in a 31-bit signed product.
- R3: The cube is scaled by an arithmetic right shift of SHIFT_K bits (default 14), which rounds toward negative infinity. For example, an edge value of −1 gives −1 and an edge value of +1 gives 0.
- R4: The scaled value saturates to the range −255 to +255 before the add. For example, an edge value of 161 gives 254, and an edge value of 162 or more gives 255.
- R5: The saturated value is added to the centre pixel, which is treated as an unsigned (zero-extended) number. A flat neighbourhood therefore returns the centre unchanged.
- R6: The sum is clamped to the output range: a negative sum gives 0 and a sum above 255 gives 255.
- R7: out_valid equals in_valid delayed by exactly five clocks. A result that is not valid is never flagged, and nothing can stall the pipeline.
- R8: While rst_n is low, out_valid and out_pix are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the neighbourhood inputs as valid this cycle |
| in_up | input | 8 | Pixel above the centre |
| in_down | input | 8 | Pixel below the centre |
| in_right | input | 8 | Pixel to the right of the centre |
| in_left | input | 8 | Pixel to the left of the centre |
| in_ctr | input | 8 | Centre pixel |
| out_valid | output | 1 | Marks out_pix as valid |
| out_pix | output | 8 | Enhanced, clamped pixel |

## Verification
Edge saturation and output clamping can act on the same pixel. A large negative edge value saturates to −255, and the sum with the centre then goes below zero and clamps to 0. The mirror case drives the sum above 255. Directed neighbourhoods with extreme contrast provoke both actions together. Directed pixels just either side of the saturation threshold (edge values 161 and 162) and small negative edges that reveal floor rounding separate the two effects. Each output is compared with a bench model that applies the shift, the saturation and the clamp in sequence. Random pixels with in_valid randomly low also test that the valid flag stays aligned with the data across bubbles.

// File: rtl/edge_cube_filter.sv
module edge_cube_filter #(
  parameter int PIX_W   = 8,
  parameter int SHIFT_K = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_up,
  input  logic [PIX_W-1:0] in_down,
  input  logic [PIX_W-1:0] in_right,
  input  logic [PIX_W-1:0] in_left,
  input  logic [PIX_W-1:0] in_ctr,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  localparam int LAP_W  = PIX_W + 3;
  localparam int SQ_W   = 2 * LAP_W - 1;
  localparam int CUBE_W = 3 * (LAP_W - 1) + 1;
  localparam int LIM_W  = PIX_W + 1;
  localparam int SUM_W  = PIX_W + 2;
  localparam int STAGES = 5;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam logic signed [CUBE_W-1:0] CUBE_HI = CUBE_W'(PIX_MAX);
  localparam logic signed [CUBE_W-1:0] CUBE_LO = -CUBE_W'(PIX_MAX);
  localparam logic signed [SUM_W-1:0]  SUM_HI  = SUM_W'(PIX_MAX);

  logic [STAGES-1:0] vld_q;

  logic signed [LAP_W-1:0]  lap_q, lap2_q;
  logic signed [SQ_W-1:0]   sq_q;
  logic signed [CUBE_W-1:0] cube_q;
  logic signed [LIM_W-1:0]  lim_q;
  logic [PIX_W-1:0]         c1_q, c2_q, c3_q, c4_q;

  logic signed [LAP_W-1:0]  lap_d;
  logic signed [CUBE_W-1:0] shr_d;
  logic signed [LIM_W-1:0]  lim_d;
  logic signed [SUM_W-1:0]  sum_d;
  logic [PIX_W-1:0]         pix_d;

  function automatic logic signed [LAP_W-1:0] widen(input logic [PIX_W-1:0] p);
    return $signed({{(LAP_W-PIX_W){1'b0}}, p});
  endfunction

  assign lap_d = (widen(in_ctr) <<< 2) - widen(in_up) - widen(in_down)
               - widen(in_right) - widen(in_left);

  assign shr_d = cube_q >>> SHIFT_K;

  always_comb begin
    if (shr_d > CUBE_HI)      lim_d = LIM_W'(PIX_MAX);
    else if (shr_d < CUBE_LO) lim_d = -LIM_W'(PIX_MAX);
    else                      lim_d = shr_d[LIM_W-1:0];
  end

  assign sum_d = $signed({2'b00, c4_q}) + SUM_W'(lim_q);

  always_comb begin
    if (sum_d < 0)           pix_d = '0;
    else if (sum_d > SUM_HI) pix_d = PIX_W'(PIX_MAX);
    else                     pix_d = sum_d[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      lap_q   <= '0;
      lap2_q  <= '0;
      sq_q    <= '0;
      cube_q  <= '0;
      lim_q   <= '0;
      c1_q    <= '0;
      c2_q    <= '0;
      c3_q    <= '0;
      c4_q    <= '0;
      out_pix <= '0;
    end else begin
      vld_q   <= {vld_q[STAGES-2:0], in_valid};
      lap_q   <= lap_d;
      c1_q    <= in_ctr;
      sq_q    <= SQ_W'(lap_q) * SQ_W'(lap_q);
      lap2_q  <= lap_q;
      c2_q    <= c1_q;
      cube_q  <= CUBE_W'(sq_q) * CUBE_W'(lap2_q);
      c3_q    <= c2_q;
      lim_q   <= lim_d;
      c4_q    <= c3_q;
      out_pix <= pix_d;
    end
  end

  assign out_valid = vld_q[STAGES-1];

  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5)));

  a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q >= -LIM_W'(PIX_MAX)) && (lim_q <= LIM_W'(PIX_MAX)));

  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q[LIM_W-1] == $past(cube_q[CUBE_W-1]));

  a_r2_cube_sign: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lap2_q) != 0) |-> (cube_q[CUBE_W-1] == $past(lap2_q[LAP_W-1])));

  a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_d < 0) |=> (out_pix == '0));

  a_r6_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_d > SUM_HI) |=> (out_pix == PIX_W'(PIX_MAX)));

  a_r8_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_pix == '0));

endmodule

// File: tb/edge_cube_filter_bench.sv
module edge_cube_filter_bench;
  localparam int CLK_NS = 10;
  localparam int NDIR   = 13;
  localparam int TOTAL  = 700;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_up = '0, in_down = '0, in_right = '0, in_left = '0, in_ctr = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] d_u[TOTAL], d_d[TOTAL], d_r[TOTAL], d_l[TOTAL], d_c[TOTAL];
  bit         d_v[TOTAL];
  string      d_tag[TOTAL];

  always #(CLK_NS/2) clk = ~clk;

  edge_cube_filter u_edge_cube_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_up(in_up), .in_down(in_down), .in_right(in_right), .in_left(in_left),
    .in_ctr(in_ctr), .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int model(input int u, input int d, input int r, input int l, input int c);
    longint lap, cube, shr, lim, sum;
    lap  = 4 * c - u - d - r - l;
    cube = lap * lap * lap;
    shr  = cube >>> 14;
    lim  = (shr > 255) ? 255 : ((shr < -255) ? -255 : shr);
    sum  = c + lim;
    if (sum < 0) return 0;
    if (sum > 255) return 255;
    return int'(sum);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input int u, input int d, input int r, input int l,
                     input int c, input bit v, input string tag);
    d_u[i] = 8'(u); d_d[i] = 8'(d); d_r[i] = 8'(r); d_l[i] = 8'(l); d_c[i] = 8'(c);
    d_v[i] = v; d_tag[i] = tag;
  endtask

  function automatic int near(input int c, input int span);
    int v;
    v = c + int'($urandom_range(2 * span)) - span;
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    put(0,  50, 50, 50, 50, 50, 1, "R5 flat");
    put(1,  0, 0, 0, 0, 255, 1, "R1 R4 R6 max edge");
    put(2,  255, 255, 255, 255, 0, 1, "R1 R4 R6 min edge");
    put(3,  101, 100, 100, 100, 100, 1, "R3 floor minus one");
    put(4,  99, 100, 100, 100, 100, 1, "R3 plus one");
    put(5,  74, 100, 100, 100, 100, 1, "R2 edge 26");
    put(6,  126, 100, 100, 100, 100, 1, "R3 edge minus 26");
    put(7,  0, 0, 0, 0, 0, 0, "R7 bubble");
    put(8,  0, 0, 0, 79, 60, 1, "R2 R4 edge 161");
    put(9,  0, 0, 0, 78, 60, 1, "R4 edge 162");
    put(10, 141, 140, 140, 140, 100, 1, "R4 R6 edge minus 161");
    put(11, 20, 20, 20, 20, 30, 1, "R5 mid add");
    put(12, 0, 0, 0, 0, 0, 0, "R7 bubble");
    for (int i = NDIR; i < TOTAL; i++) begin
      int c, sp;
      c  = int'($urandom_range(255));
      sp = ($urandom_range(1) == 0) ? 40 : 255;
      put(i, near(c, sp), near(c, sp), near(c, sp), near(c, sp), c,
          $urandom_range(3) != 0, "R1 R2 R3 R4 R5 R6 random");
    end

    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check("R8 reset valid", int'(out_valid), 0);
    check("R8 reset pix", int'(out_pix), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < TOTAL + 6; i++) begin
      @(negedge clk);
      if (i >= 5) begin
        int j;
        j = i - 5;
        check({"R7 valid ", d_tag[j]}, int'(out_valid), int'(d_v[j]));
        if (d_v[j])
          check(d_tag[j], int'(out_pix),
                model(d_u[j], d_d[j], d_r[j], d_l[j], d_c[j]));
      end
      if (i < TOTAL) begin
        in_valid = d_v[i];
        in_up = d_u[i]; in_down = d_d[i]; in_right = d_r[i];
        in_left = d_l[i]; in_ctr = d_c[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule